// File: doc/BRIEF.md
# Indexed Register Window with Version Negotiation

This block is a display controller's register bank that the host reaches through a few word-wide I/O ports. The host first writes a register number to the index port. A read or write on the value port then reaches the register that number selects. A third port holds one plain word that boot firmware can use.

Behind the window sit several groups of state:
- an identification register through which the host and the device agree on an interface version;
- mode and control words;
- a request/busy handshake towards a drawing engine, which is outside this block;
- a colour palette of three components per colour;
- a small block of scratch words.

In version 0 the extended control registers are absent and the palette moves down to start directly after the base registers. In versions 1 and up the palette sits at a high fixed index range, and the scratch block follows it.

Every port read returns data with a fixed latency of two clock cycles, marked by `rvalid`. The palette and scratch storage are written so that block RAM can be inferred.

Top module: `irf_port`

## Requirements
- R1: A write to port 0 (index port) stores the low IDX_W (16) bits of `wdata`. A read of port 0 returns that index, zero-extended. For every read, `rdata` is valid and `rvalid` is high exactly two clock cycles after the cycle in which `rd_en` is high, and `rvalid` is low in the cycle between.
- R2: After reset, register 0 reads 0x90000002, the busy register (22) reads 0, and `rdata`, `rvalid` and `eng_kick` are 0.
- R3: A write to register 0 is latched when bits 31:8 equal 0x900000 and bits 7:0 hold a version of at most MAX_VER (2). Any other value, including 0xFFFFFFFF, makes register 0 read the highest identifier, 0x90000002.
- R4: The plain mode and control registers (every number below 33 except 0, 4, 5, 17, 21, 22, 28, 29) store and read back full 32-bit values.
- R5: Registers 4 (2360), 5 (1770), 17 (0x00000060), 28 (32) and 29 (scratch count, 8) return fixed values, and writes to them are ignored.
- R6: A write to register 21 sets busy, so register 22 reads 1, and raises `eng_kick` for exactly one cycle. A one-cycle pulse on `eng_done` clears busy. Reading register 22 does not change busy.
- R7: In version 1 and above, indices 1024 to 1791 reach the palette. Each entry keeps the low 8 bits of the written value and reads back zero-extended.
- R8: In version 1 and above, indices 1792 to 1799 reach the eight 32-bit scratch words.
- R9: In version 0, indices 17 to 784 reach the same palette entries, starting at entry 0. The extended registers 17 to 32 are unreachable there, so a write to index 21 raises no `eng_kick`. Indices of 1024 and above read 0.
- R10: Register 27 (cursor state) accepts only 0 (hide), 1 (show), 2 (lift from image) and 3 (put back). A write of any larger value is ignored.
- R11: Unimplemented indices, such as 33, 1000 and 1800, read 0 and ignore writes. Port 2 is a plain 32-bit read/write word. Port 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 2 | Port select: 0 index, 1 value, 2 firmware word, 3 unused |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe for the selected port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid when rvalid is high |
| rvalid | output | 1 | Read data valid, two cycles after rd_en |
| eng_kick | output | 1 | One-cycle request to the drawing engine on a sync write |
| eng_done | input | 1 | Pulse from the drawing engine when the request is finished |

## Verification
The window is driven with indices that fall in each region under each negotiated version. An index such as 17 or 21 reaches a control register in one version and a palette entry in the other, so decoding errors that depend on the version become visible. Wide data patterns written to the palette separate truncation to the component width from full-word storage. Reads placed just past each region (33, 785, 1800) show where every range ends. Identification writes with a legal version, an over-range version, a wrong magic value and the invalid all-ones word tell apart acceptance and each form of fallback to the highest identifier. Reading the palette again after switching back from version 0 shows that both versions address the same storage.

// File: rtl/irf_pkg.sv
package irf_pkg;
  localparam logic [23:0] ID_MAGIC = 24'h900000;

  localparam int REG_TOP       = 33;
  localparam int REG_EXT_FIRST = 17;
  localparam int PAL_BASE_V0   = 17;
  localparam int PAL_BASE_V1   = 1024;

  localparam int RN_ID      = 0;
  localparam int RN_MAXW    = 4;
  localparam int RN_MAXH    = 5;
  localparam int RN_CAPS    = 17;
  localparam int RN_SYNC    = 21;
  localparam int RN_BUSY    = 22;
  localparam int RN_CURSOR  = 27;
  localparam int RN_HOSTBPP = 28;
  localparam int RN_SCRN    = 29;

  typedef enum logic [1:0] {RG_NONE, RG_REG, RG_PAL, RG_SCR} region_e;

  localparam logic [1:0] PT_INDEX = 2'd0;
  localparam logic [1:0] PT_VALUE = 2'd1;
  localparam logic [1:0] PT_BIOS  = 2'd2;
endpackage

// File: rtl/irf_id_negotiate.sv
module irf_id_negotiate
  import irf_pkg::*;
#(
  parameter int MAX_VER = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        id_wr,
  input  logic [31:0] wdata,
  output logic [31:0] id_q,
  output logic        ver_zero
);
  localparam logic [31:0] ID_TOP = {ID_MAGIC, 8'(MAX_VER)};

  logic accept;
  assign accept = (wdata[31:8] == ID_MAGIC) && (int'(wdata[7:0]) <= MAX_VER);

  always_ff @(posedge clk) begin
    if (rst)        id_q <= ID_TOP;
    else if (id_wr) id_q <= accept ? wdata : ID_TOP;
  end

  assign ver_zero = (id_q[7:0] == 8'd0);

  AST_ID_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (id_q[31:8] == ID_MAGIC) && (int'(id_q[7:0]) <= MAX_VER)); // R3
  AST_ID_INVALID_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    (id_wr && wdata == 32'hFFFF_FFFF) |=> (id_q == ID_TOP)); // R3
endmodule

// File: rtl/irf_sync_busy.sv
module irf_sync_busy (
  input  logic clk,
  input  logic rst,
  input  logic sync_wr,
  input  logic eng_done,
  output logic busy,
  output logic kick
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      kick <= 1'b0;
    end else begin
      kick <= sync_wr;
      if (sync_wr)       busy <= 1'b1;
      else if (eng_done) busy <= 1'b0;
    end
  end

  AST_SYNC_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    sync_wr |=> busy); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !sync_wr) |=> !busy); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done) |=> busy); // R6
  AST_KICK_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
    kick |-> busy); // R6
endmodule

// File: rtl/irf_ctl_regs.sv
module irf_ctl_regs
  import irf_pkg::*;
#(
  parameter int          IDX_W    = 16,
  parameter int          MAX_W    = 2360,
  parameter int          MAX_H    = 1770,
  parameter logic [31:0] CAPS     = 32'h0000_0060,
  parameter int          HOST_BPP = 32,
  parameter int          SCR_N    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  input  logic [31:0]      id_val,
  input  logic             busy,
  output logic [31:0]      rd_word
);
  localparam int SEL_W = $clog2(REG_TOP);

  logic [31:0] regs_q [REG_TOP];

  function automatic logic plain_rw(input int n);
    return !(n inside {RN_ID, RN_MAXW, RN_MAXH, RN_CAPS, RN_SYNC,
                       RN_BUSY, RN_HOSTBPP, RN_SCRN});
  endfunction

  always_ff @(posedge clk) begin
    for (int n = 0; n < REG_TOP; n++) begin
      if (rst) begin
        regs_q[n] <= '0;
      end else if (wr && plain_rw(n) && int'(idx) == n &&
                   (n != RN_CURSOR || wdata <= 32'd3)) begin
        regs_q[n] <= wdata;
      end
    end
  end

  always_comb begin
    case (int'(idx))
      RN_ID:      rd_word = id_val;
      RN_MAXW:    rd_word = 32'(MAX_W);
      RN_MAXH:    rd_word = 32'(MAX_H);
      RN_CAPS:    rd_word = CAPS;
      RN_SYNC:    rd_word = '0;
      RN_BUSY:    rd_word = {31'd0, busy};
      RN_HOSTBPP: rd_word = 32'(HOST_BPP);
      RN_SCRN:    rd_word = 32'(SCR_N);
      default:    rd_word = (int'(idx) < REG_TOP) ? regs_q[idx[SEL_W-1:0]] : '0;
    endcase
  end

  AST_CURSOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    regs_q[RN_CURSOR] <= 32'd3); // R10
  AST_WIDTH_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr && int'(idx) == 2) |=> (regs_q[2] == $past(wdata))); // R4
endmodule

// File: rtl/irf_word_ram.sv
module irf_word_ram #(
  parameter int DEPTH = 768,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/irf_port.sv
module irf_port
  import irf_pkg::*;
#(
  parameter int          IDX_W      = 16,
  parameter int          MAX_VER    = 2,
  parameter int          PAL_COLORS = 256,
  parameter int          COMP_W     = 8,
  parameter int          SCR_N      = 8,
  parameter int          MAX_W      = 2360,
  parameter int          MAX_H      = 1770,
  parameter logic [31:0] CAPS       = 32'h0000_0060,
  parameter int          HOST_BPP   = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  port_sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rvalid,
  output logic        eng_kick,
  input  logic        eng_done
);
  localparam int PAL_N    = 3 * PAL_COLORS;
  localparam int PAL_AW   = $clog2(PAL_N);
  localparam int SCR_AW   = $clog2(SCR_N);
  localparam int SCR_BASE = PAL_BASE_V1 + PAL_N;

  logic [IDX_W-1:0] idx_q;
  logic [31:0]      bios_q;
  logic [31:0]      id_q;
  logic             ver_zero;
  logic             busy;
  logic [31:0]      ctl_rd;
  region_e          region;
  int               idx_i;

  assign idx_i = int'(idx_q);

  // Region decode; the layout depends on the negotiated version
  always_comb begin
    region = RG_NONE;
    if (ver_zero) begin
      if (idx_i < REG_EXT_FIRST)              region = RG_REG;
      else if (idx_i < PAL_BASE_V0 + PAL_N)   region = RG_PAL;
    end else begin
      if (idx_i < REG_TOP)                    region = RG_REG;
      else if (idx_i >= PAL_BASE_V1 && idx_i < SCR_BASE)       region = RG_PAL;
      else if (idx_i >= SCR_BASE && idx_i < SCR_BASE + SCR_N)  region = RG_SCR;
    end
  end

  logic val_wr, val_rd, reg_wr, id_wr, sync_wr;
  assign val_wr  = wr_en && (port_sel == PT_VALUE);
  assign val_rd  = rd_en && (port_sel == PT_VALUE);
  assign reg_wr  = val_wr && (region == RG_REG);
  assign id_wr   = reg_wr && (idx_i == RN_ID);
  assign sync_wr = reg_wr && (idx_i == RN_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      bios_q <= '0;
    end else if (wr_en) begin
      if (port_sel == PT_INDEX) idx_q  <= wdata[IDX_W-1:0];
      if (port_sel == PT_BIOS)  bios_q <= wdata;
    end
  end

  irf_id_negotiate #(.MAX_VER(MAX_VER)) u_id (
    .clk(clk), .rst(rst), .id_wr(id_wr), .wdata(wdata),
    .id_q(id_q), .ver_zero(ver_zero)
  );

  irf_sync_busy u_sync (
    .clk(clk), .rst(rst), .sync_wr(sync_wr), .eng_done(eng_done),
    .busy(busy), .kick(eng_kick)
  );

  irf_ctl_regs #(
    .IDX_W(IDX_W), .MAX_W(MAX_W), .MAX_H(MAX_H), .CAPS(CAPS),
    .HOST_BPP(HOST_BPP), .SCR_N(SCR_N)
  ) u_ctl (
    .clk(clk), .rst(rst), .wr(reg_wr), .idx(idx_q), .wdata(wdata),
    .id_val(id_q), .busy(busy), .rd_word(ctl_rd)
  );

  // Palette and scratch storage
  logic [PAL_AW-1:0] pal_addr;
  logic [COMP_W-1:0] pal_q;
  logic [SCR_AW-1:0] scr_addr;
  logic [31:0]       scr_q;

  assign pal_addr = ver_zero ? PAL_AW'(idx_i - PAL_BASE_V0) : PAL_AW'(idx_i - PAL_BASE_V1);
  assign scr_addr = SCR_AW'(idx_i - SCR_BASE);

  irf_word_ram #(.DEPTH(PAL_N), .WIDTH(COMP_W)) u_pal (
    .clk(clk), .we(val_wr && region == RG_PAL), .re(val_rd && region == RG_PAL),
    .addr(pal_addr), .wdata(wdata[COMP_W-1:0]), .q(pal_q)
  );

  irf_word_ram #(.DEPTH(SCR_N), .WIDTH(32)) u_scr (
    .clk(clk), .we(val_wr && region == RG_SCR), .re(val_rd && region == RG_SCR),
    .addr(scr_addr), .wdata(wdata), .q(scr_q)
  );

  // Two-stage read pipeline: select and capture, then final mux register
  logic        s1_valid;
  region_e     s1_src;
  logic [31:0] s1_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_src   <= RG_NONE;
      s1_word  <= '0;
      rdata    <= '0;
      rvalid   <= 1'b0;
    end else begin
      s1_valid <= rd_en;
      s1_src   <= val_rd ? region : RG_NONE;
      case (port_sel)
        PT_INDEX: s1_word <= 32'(idx_q);
        PT_BIOS:  s1_word <= bios_q;
        PT_VALUE: s1_word <= (region == RG_REG) ? ctl_rd : '0;
        default:  s1_word <= '0;
      endcase
      rvalid <= s1_valid;
      if (s1_valid) begin
        case (s1_src)
          RG_PAL:  rdata <= 32'(pal_q);
          RG_SCR:  rdata <= scr_q;
          default: rdata <= s1_word;
        endcase
      end
    end
  end

  AST_INDEX_LATCH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_sel == PT_INDEX) |=> (idx_q == $past(wdata[IDX_W-1:0]))); // R1
  AST_PAL_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (rvalid && $past(s1_src) == RG_PAL) |-> (rdata[31:COMP_W] == '0)); // R7
endmodule

// File: tb/sim_irf_port.sv
`timescale 1ns/1ps
module sim_irf_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  port_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        eng_kick;
  logic        eng_done = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  int kick_cnt = 0;
  logic mid_valid;

  always #4 clk = ~clk;

  irf_port u0 (
    .clk(clk), .rst(rst), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .eng_kick(eng_kick),
    .eng_done(eng_done)
  );

  always @(negedge clk) if (eng_kick) kick_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic [31:0] d);
    @(negedge clk);
    port_sel = p; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, output logic [31:0] d);
    @(negedge clk);
    port_sel = p; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    mid_valid = rvalid;
    @(negedge clk);
    if (rvalid !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: rvalid actual %0b expected 1", rvalid);
    end
    d = rdata;
  endtask

  task automatic wreg(input int idx, input logic [31:0] d);
    wr(2'd0, 32'(idx));
    wr(2'd1, d);
  endtask

  task automatic rreg(input int idx, output logic [31:0] d);
    wr(2'd0, 32'(idx));
    rd(2'd1, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R2 rdata", rdata, 32'd0);
    chk("R2 rvalid", 32'(rvalid), 32'd0);
    chk("R2 kick", 32'(eng_kick), 32'd0);
    rreg(0, v);  chk("R2 id", v, 32'h9000_0002);
    rreg(22, v); chk("R2 busy", v, 32'd0);
  endtask

  task automatic t_index;
    logic [31:0] v;
    wr(2'd0, 32'h1234_0005);
    rd(2'd0, v);
    chk("R1 index readback", v, 32'h0000_0005);
    chk("R1 rvalid low mid", 32'(mid_valid), 32'd0);
  endtask

  task automatic t_modes;
    logic [31:0] v;
    wreg(2, 32'h0000_0500);
    wreg(3, 32'h0000_03C0);
    wreg(12, 32'hDEAD_BEEF);
    rreg(2, v);  chk("R4 reg2", v, 32'h0000_0500);
    rreg(3, v);  chk("R4 reg3", v, 32'h0000_03C0);
    rreg(12, v); chk("R4 reg12", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wreg(4, 32'd0);     rreg(4, v);  chk("R5 maxw", v, 32'd2360);
    wreg(5, 32'd7);     rreg(5, v);  chk("R5 maxh", v, 32'd1770);
    wreg(17, 32'hFFFF); rreg(17, v); chk("R5 caps", v, 32'h0000_0060);
    wreg(28, 32'd8);    rreg(28, v); chk("R5 hostbpp", v, 32'd32);
    wreg(29, 32'd99);   rreg(29, v); chk("R5 scratch count", v, 32'd8);
  endtask

  task automatic t_sync;
    logic [31:0] v;
    wr(2'd0, 32'd21);
    wr(2'd1, 32'd1);
    chk("R6 kick high", 32'(eng_kick), 32'd1);
    @(negedge clk);
    chk("R6 kick one cycle", 32'(eng_kick), 32'd0);
    rreg(22, v); chk("R6 busy set", v, 32'd1);
    rd(2'd1, v); chk("R6 busy read no side effect", v, 32'd1);
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    rd(2'd1, v); chk("R6 busy cleared", v, 32'd0);
  endtask

  task automatic t_cursor;
    logic [31:0] v;
    wreg(27, 32'd2); rreg(27, v); chk("R10 cursor 2", v, 32'd2);
    wreg(27, 32'd7); rreg(27, v); chk("R10 cursor illegal ignored", v, 32'd2);
    wreg(27, 32'd3); rreg(27, v); chk("R10 cursor 3", v, 32'd3);
  endtask

  task automatic t_palette;
    logic [31:0] v;
    wreg(1024, 32'h0000_01AB);
    wreg(1791, 32'hFFFF_FF55);
    rreg(1024, v); chk("R7 pal first", v, 32'h0000_00AB);
    rreg(1791, v); chk("R7 pal last", v, 32'h0000_0055);
  endtask

  task automatic t_scratch;
    logic [31:0] v;
    wreg(1792, 32'hCAFE_F00D);
    wreg(1799, 32'h0102_0304);
    rreg(1792, v); chk("R8 scratch first", v, 32'hCAFE_F00D);
    rreg(1799, v); chk("R8 scratch last", v, 32'h0102_0304);
  endtask

  task automatic t_unimpl;
    logic [31:0] v;
    wreg(33, 32'h1111_1111);   rreg(33, v);   chk("R11 idx33", v, 32'd0);
    wreg(1000, 32'h2222_2222); rreg(1000, v); chk("R11 idx1000", v, 32'd0);
    wreg(1800, 32'h3333_3333); rreg(1800, v); chk("R11 idx1800", v, 32'd0);
    wr(2'd2, 32'h0000_0077);   rd(2'd2, v);   chk("R11 fw word", v, 32'h0000_0077);
    wr(2'd3, 32'h4444_4444);   rd(2'd3, v);   chk("R11 port3", v, 32'd0);
  endtask

  task automatic t_ident;
    logic [31:0] v;
    wreg(0, 32'h9000_0001); rreg(0, v); chk("R3 accept v1", v, 32'h9000_0001);
    wreg(0, 32'h9000_0003); rreg(0, v); chk("R3 over-range", v, 32'h9000_0002);
    wreg(0, 32'h9000_0001);
    wreg(0, 32'hFFFF_FFFF); rreg(0, v); chk("R3 invalid id", v, 32'h9000_0002);
    wreg(0, 32'h9000_0001);
    wreg(0, 32'h1234_5601); rreg(0, v); chk("R3 bad magic", v, 32'h9000_0002);
  endtask

  task automatic t_version0;
    logic [31:0] v;
    int k0;
    wreg(0, 32'h9000_0000); rreg(0, v); chk("R9 accept v0", v, 32'h9000_0000);
    wreg(17, 32'h0000_003C);
    k0 = kick_cnt;
    wreg(21, 32'h0000_0009);
    chk("R9 no kick at idx21", 32'(kick_cnt - k0), 32'd0);
    wreg(784, 32'h0000_00E7);
    rreg(17, v);   chk("R9 v0 pal entry0", v, 32'h0000_003C);
    rreg(784, v);  chk("R9 v0 pal last", v, 32'h0000_00E7);
    rreg(785, v);  chk("R9 v0 past pal", v, 32'd0);
    rreg(1024, v); chk("R9 v0 high idx", v, 32'd0);
    rreg(12, v);   chk("R9 v0 base reg kept", v, 32'hDEAD_BEEF);
    wreg(0, 32'h9000_0001);
    rreg(1024, v); chk("R9 shared entry0", v, 32'h0000_003C);
    rreg(1028, v); chk("R9 shared entry4", v, 32'h0000_0009);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_index();
    t_modes();
    t_readonly();
    t_sync();
    t_cursor();
    t_palette();
    t_scratch();
    t_unimpl();
    t_ident();
    t_version0();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule